// File: doc/BRIEF.md
# Timer Input Edge Detector with Count Gate

This block sits between an asynchronous external timer input pin and a channel's up/down counter. It samples the pin on the channel operation clock through a synchronizer chain and, optionally, a noise filter. When the resulting level goes from low to high, it emits a count-enable pulse one clock wide. A start strobe arms the block, which then waits for the next qualifying edge. A stop strobe disarms it, and no pulse leaves the block while it is disarmed.

The filter admits a new level only after that level has been seen on `FILT_DEPTH` consecutive clock edges at the synchronizer output. Short glitches therefore never reach the counter. The synchronizer and filter keep running while the block is disarmed, so an input that is already high when the block is re-armed does not count as an edge. A second output, the counter-update strobe, repeats the count enable one clock later. It marks the cycle in which the downstream counter actually changes its value.

Top module: `tin_edge_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `enabled`, `countEn` and `cntUpdate` are all low.
- R2: A cycle with `startStb` high and `stopStb` low sets `enabled` at the next clock. A cycle with `stopStb` high clears it at the next clock, even when `startStb` is also high. With neither strobe high, `enabled` holds its value.
- R3: `countEn` never goes high in a cycle where `enabled` is low. This covers the time before the first start and the time after a stop.
- R4: Each low-to-high change of the qualified input level gives exactly one `countEn` pulse, one clock wide. An input held high gives no further pulses.
- R5: With `filterEn` low and default parameters, `countEn` rises more than 1 and at most 2 clock periods after the pin rises. A pin high at only one sampling edge still yields a pulse.
- R6: With `filterEn` high and default parameters, `countEn` rises more than 3 and at most 4 clock periods after the pin rises.
- R7: With `filterEn` high, a pin level present at fewer than `FILT_DEPTH` (default 2) consecutive sampling edges produces no pulse.
- R8: `cntUpdate` is high exactly in the cycle after each cycle in which `countEn` is high.
- R9: If the pin is already high when the block is started, no pulse follows until the pin falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel operation clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | External timer input, asynchronous to clk |
| filterEn | input | 1 | 1 = qualify the level through the noise filter |
| startStb | input | 1 | One-cycle strobe that arms the block |
| stopStb | input | 1 | One-cycle strobe that disarms the block (has priority over start) |
| enabled | output | 1 | High while the block is armed |
| countEn | output | 1 | One-cycle count-enable pulse per qualified rising edge |
| cntUpdate | output | 1 | countEn delayed by one clock; the counter update cycle |

## Verification
The bench uses the default parameters: `SYNC_STAGES` = 2 and `FILT_DEPTH` = 2. These give fixed latency windows of 1–2 clocks without the filter and 3–4 clocks with it. A pin rise placed a fixed offset after a clock edge therefore has a single expected arrival time that the bench can measure in nanoseconds. A depth of 2 also makes a one-edge glitch the shortest pulse the filter must reject. Directed one-edge pulses, held levels at start and stop/start collisions can then be laid against a cycle model that runs alongside the random traffic.

// File: rtl/tin_pkg.sv
package tin_pkg;

  typedef struct packed {
    logic gateOpen;   // detection result may leave the block
    logic useFilter;  // qualified level taken from the noise filter
  } tinCtl_t;

endpackage

// File: rtl/tin_ctrl.sv
module tin_ctrl
  import tin_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startStb,
  input  logic    stopStb,
  input  logic    filterEn,
  output tinCtl_t ctl,
  output logic    enabled
);

  logic armQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ <= 1'b0;
    end else if (stopStb) begin
      armQ <= 1'b0;
    end else if (startStb) begin
      armQ <= 1'b1;
    end
  end

  always_comb begin
    ctl.gateOpen  = armQ;
    ctl.useFilter = filterEn;
  end

  assign enabled = armQ;

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !stopStb) |=> enabled); // R2
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> !enabled); // R2
  AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!startStb && !stopStb) |=> (enabled == $past(enabled))); // R2

endmodule

// File: rtl/tin_datapath.sv
module tin_datapath
  import tin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pinIn,
  input  tinCtl_t ctl,
  output logic    countEn,
  output logic    cntUpdate
);

  localparam int HistW = FILT_DEPTH - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [HistW-1:0]       histQ;
  logic [FILT_DEPTH-1:0]  window;
  logic                   filtQ;
  logic                   level;
  logic                   levelD;
  logic                   updQ;

  // synchronizer chain, oldest sample at the top bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  // history of synchronized samples for the filter window
  generate
    if (HistW > 1) begin : g_histShift
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) histQ <= '0;
        else       histQ <= {histQ[HistW-2:0], syncOut};
      end
    end else begin : g_histSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) histQ <= '0;
        else       histQ <= syncOut;
      end
    end
  endgenerate

  assign window = {histQ, syncOut};

  // filter output moves only when the whole window agrees
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         filtQ <= 1'b0;
    else if (&window)  filtQ <= 1'b1;
    else if (~|window) filtQ <= 1'b0;
  end

  assign level = ctl.useFilter ? filtQ : syncOut;

  // edge history keeps running while disarmed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelD <= 1'b0;
      updQ   <= 1'b0;
    end else begin
      levelD <= level;
      updQ   <= countEn;
    end
  end

  assign countEn   = ctl.gateOpen & level & ~levelD;
  assign cntUpdate = updQ;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    countEn |=> !countEn); // R4
  AST_UPDATE_LAG: assert property (@(posedge clk) disable iff (!rstN)
    countEn |=> cntUpdate); // R8
  AST_UPDATE_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> !cntUpdate); // R8
  AST_FILTER_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && ctl.useFilter && $past(ctl.useFilter)) |-> $past(syncOut)); // R7
  AST_RAW_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !ctl.useFilter && !$past(ctl.useFilter)) |-> (syncOut && !$past(syncOut))); // R5

endmodule

// File: rtl/tin_edge_gate.sv
module tin_edge_gate
  import tin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic filterEn,
  input  logic startStb,
  input  logic stopStb,
  output logic enabled,
  output logic countEn,
  output logic cntUpdate
);

  tinCtl_t ctlBus;

  tin_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .stopStb  (stopStb),
    .filterEn (filterEn),
    .ctl      (ctlBus),
    .enabled  (enabled)
  );

  tin_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_DEPTH  (FILT_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .ctl       (ctlBus),
    .countEn   (countEn),
    .cntUpdate (cntUpdate)
  );

  AST_NO_PULSE_DISARMED: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> !countEn); // R3

endmodule

// File: tb/sim_tin_edge_gate.sv
module sim_tin_edge_gate;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b0;
  logic filterEn = 1'b0;
  logic startStb = 1'b0;
  logic stopStb = 1'b0;
  logic enabled, countEn, cntUpdate;

  int nChecked = 0;
  int nBad = 0;
  int pulseCnt = 0;
  realtime tRise, tCe;

  always #5 clk = ~clk;

  tin_edge_gate u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .filterEn(filterEn),
    .startStb(startStb), .stopStb(stopStb),
    .enabled(enabled), .countEn(countEn), .cntUpdate(cntUpdate)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecked++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nBad);
  endtask

  // cycle model built from the requirements (default parameters)
  logic m1, m2, mHist, mFilt, mLvlD, mEn, mUpd;
  logic expCe;

  function automatic logic qualLevel(input logic useF, input logic f, input logic s);
    return useF ? f : s;
  endfunction

  function automatic logic expPulse(input logic en, input logic lvl, input logic prev);
    return en && lvl && !prev;
  endfunction

  assign expCe = expPulse(mEn, qualLevel(filterEn, mFilt, m2), mLvlD);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 0; m2 <= 0; mHist <= 0; mFilt <= 0; mLvlD <= 0; mEn <= 0; mUpd <= 0;
    end else begin
      m1 <= pinIn;
      m2 <= m1;
      mHist <= m2;
      if (m2 == mHist) mFilt <= m2;
      mLvlD <= qualLevel(filterEn, mFilt, m2);
      if (stopStb) mEn <= 0;
      else if (startStb) mEn <= 1;
      mUpd <= expCe;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(countEn === expCe, "R4 countEn vs model", int'(countEn), int'(expCe));
      check(cntUpdate === mUpd, "R8 cntUpdate vs model", int'(cntUpdate), int'(mUpd));
      check(enabled === mEn, "R2 enabled vs model", int'(enabled), int'(mEn));
      if (!enabled) check(countEn === 1'b0, "R3 no pulse disarmed", int'(countEn), 0);
      if (countEn) pulseCnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic strobe(input bit st, input bit sp);
    @(posedge clk); #2;
    startStb = st; stopStb = sp;
    @(posedge clk); #2;
    startStb = 0; stopStb = 0;
  endtask

  task automatic measure(input real lo, input real hi, input string req);
    pinIn = 0;
    tick(6);
    pulseCnt = 0;
    @(posedge clk); #3;
    pinIn = 1;
    tRise = $realtime;
    tCe = 0;
    fork
      begin @(posedge countEn); tCe = $realtime; end
      begin #100; end
    join_any
    disable fork;
    check((tCe - tRise) > lo && (tCe - tRise) <= hi, req, int'(tCe - tRise), int'(hi));
    @(negedge clk);
    @(negedge clk);
    check(cntUpdate === 1'b1, "R8 update one cycle later", int'(cntUpdate), 1);
    tick(8);
    check(pulseCnt == 1, "R4 single pulse for held level", pulseCnt, 1);
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({enabled, countEn, cntUpdate} === 3'b000, "R1 outputs in reset", int'({enabled, countEn, cntUpdate}), 0);
    @(posedge clk); #2;
    rstN = 1;
    @(negedge clk);
    check({enabled, countEn, cntUpdate} === 3'b000, "R1 outputs after reset", int'({enabled, countEn, cntUpdate}), 0);

    // R3: edges before start are not counted
    pulseCnt = 0;
    tick(1); pinIn = 1; tick(5); pinIn = 0; tick(5);
    check(pulseCnt == 0, "R3 no pulse before start", pulseCnt, 0);

    // R2: start arms
    strobe(1, 0);
    check(enabled === 1'b1, "R2 start arms", int'(enabled), 1);

    // R5: raw latency and one-edge pulse
    measure(10.0, 20.0, "R5 latency without filter ns");
    pinIn = 0; tick(5); pulseCnt = 0;
    @(posedge clk); #3; pinIn = 1;
    @(posedge clk); #3; pinIn = 0;
    tick(8);
    check(pulseCnt == 1, "R5 one-edge pulse counted without filter", pulseCnt, 1);

    // R6 / R7: filtered latency and glitch rejection
    filterEn = 1;
    measure(30.0, 40.0, "R6 latency with filter ns");
    pinIn = 0; tick(6); pulseCnt = 0;
    @(posedge clk); #3; pinIn = 1;
    @(posedge clk); #3; pinIn = 0;
    tick(10);
    check(pulseCnt == 0, "R7 one-edge glitch rejected", pulseCnt, 0);
    filterEn = 0; tick(4);

    // R3: stop suppresses later edges
    strobe(0, 1);
    check(enabled === 1'b0, "R2 stop disarms", int'(enabled), 0);
    pulseCnt = 0;
    pinIn = 1; tick(6);
    check(pulseCnt == 0, "R3 no pulse after stop", pulseCnt, 0);

    // R9: input already high at start
    strobe(1, 0);
    tick(8);
    check(pulseCnt == 0, "R9 high input at start not counted", pulseCnt, 0);
    pinIn = 0; tick(4); pinIn = 1; tick(6);
    check(pulseCnt == 1, "R9 later fresh edge counted", pulseCnt, 1);

    // R2: stop has priority over start
    strobe(1, 1);
    check(enabled === 1'b0, "R2 stop wins over start", int'(enabled), 0);

    // random traffic against the model
    pinIn = 0;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      if ($urandom_range(0, 3) == 0) pinIn = ~pinIn;
      startStb = ($urandom_range(0, 19) == 0);
      stopStb  = ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 99) == 0) filterEn = ~filterEn;
    end
    @(posedge clk); #2;
    startStb = 0; stopStb = 0;
    tick(4);

    summary();
    $finish;
  end

endmodule